// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block owns the SDRAM command bus from reset until the memory is ready for normal traffic. After a synchronous reset it keeps the bus idle with clock enable and data mask both high for a long settling pause. The pause length is given in microseconds and converted to clock cycles from a clock-frequency parameter. The block then closes every bank with one precharge, writes the mode register with a word fixed by a parameter, and issues a burst of auto-refresh commands. Every command is followed by its own minimum run of idle cycles.

A parameter chooses whether the refresh burst comes before or after the mode write. When the last idle run has elapsed, a done flag rises and stays high until the next reset. From then on the bus idles and the data mask drops. The block is meant to sit in front of a memory controller's command multiplexer, which hands the bus to normal traffic once done is seen. Its pins carry control levels only, so there is no handshake.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, the bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111, address 0) for exactly PAUSE_US*CLK_MHZ cycles, counted from the first cycle after reset is released, and done is low.
- R2: Clock enable is high in every cycle. The data mask is high in every cycle where done is low and low once done is high.
- R3: The cycle right after the pause carries one precharge-all: {cs_n,ras_n,cas_n,we_n} = 4'b0010, address bit 10 high and every other address bit low.
- R4: Exactly T_RP NOP cycles follow the precharge-all before the next command.
- R5: The mode register set is encoded as 4'b0000, with MODE_WORD on the address bus. It is issued exactly once, and only after the precharge-all.
- R6: Exactly T_RSC NOP cycles follow the mode register set before any further command or done.
- R7: Exactly REF_COUNT auto-refresh commands are issued, each encoded as 4'b0001 with address 0.
- R8: Exactly T_RC NOP cycles follow each auto-refresh before the next command or done.
- R9: With REFRESH_FIRST = 0 the mode register set comes directly after the precharge wait and is followed by the refresh burst. With REFRESH_FIRST = 1 the refresh burst comes first and the mode register set last.
- R10: Done rises in the cycle after the last idle cycle of the final command's wait, stays high, and the bus shows NOP from then on.
- R11: A synchronous reset asserted at any point, including in the middle of the refresh burst, returns the outputs to the R1 state and replays the full sequence from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| clk_en | output | 1 | Memory clock enable |
| dq_mask | output | 1 | Data mask, high keeps the data bus quiet |
| addr | output | ADDR_W | Address bus: mode word or precharge-all flag |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The hardest conditions to reach from the ports are the late ones: a refresh landing on the tail of the burst, the handover to done, and a reset that strikes in the middle of the burst. With a real pause these lie tens of thousands of cycles out. The bench shortens the pause through the frequency and pause parameters and runs one instance for each ordering side by side. It compares every output in every cycle against a schedule computed arithmetically from the parameters. It then resets both instances partway through the refresh burst and sweeps the whole replay again.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_MRS = 2'd2,
    CMD_REF = 2'd3
  } init_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_PRE  = 3'd1,
    ST_MRS  = 3'd2,
    ST_REF  = 3'd3,
    ST_DONE = 3'd4
  } init_state_e;

  // Returns {cs_n, ras_n, cas_n, we_n} for a command.
  function automatic logic [3:0] cmd_pins(init_cmd_e c);
    case (c)
      CMD_PRE: cmd_pins = 4'b0010;
      CMD_MRS: cmd_pins = 4'b0000;
      CMD_REF: cmd_pins = 4'b0001;
      default: cmd_pins = 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= W'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_timer_reload_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int T_RP          = 2,
  parameter int T_RC          = 8,
  parameter int T_RSC         = 2,
  parameter int REF_COUNT     = 8,
  parameter bit REFRESH_FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output init_cmd_e        cmd,
  output logic             done
);

  localparam int REF_W = $clog2(REF_COUNT + 1);

  init_state_e      st_q, st_d;
  logic             pre_q, mrs_q;
  logic [REF_W-1:0] ref_q;
  logic             refs_left;

  assign refs_left = (ref_q < REF_W'(REF_COUNT));

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    case (st_q)
      ST_WAIT: begin
        if (expired) begin
          if (!pre_q)             st_d = ST_PRE;
          else if (REFRESH_FIRST) st_d = refs_left ? ST_REF : (!mrs_q ? ST_MRS : ST_DONE);
          else                    st_d = !mrs_q ? ST_MRS : (refs_left ? ST_REF : ST_DONE);
        end
      end
      ST_PRE: begin
        load     = 1'b1;
        load_val = CNT_W'(T_RP - 1);
        st_d     = ST_WAIT;
      end
      ST_MRS: begin
        load     = 1'b1;
        load_val = CNT_W'(T_RSC - 1);
        st_d     = ST_WAIT;
      end
      ST_REF: begin
        load     = 1'b1;
        load_val = CNT_W'(T_RC - 1);
        st_d     = ST_WAIT;
      end
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_WAIT;
      pre_q <= 1'b0;
      mrs_q <= 1'b0;
      ref_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_PRE) pre_q <= 1'b1;
      if (st_q == ST_MRS) mrs_q <= 1'b1;
      if (st_q == ST_REF) ref_q <= ref_q + 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      ST_PRE:  cmd = CMD_PRE;
      ST_MRS:  cmd = CMD_MRS;
      ST_REF:  cmd = CMD_REF;
      default: cmd = CMD_NOP;
    endcase
  end

  assign done = (st_q == ST_DONE);

  p_pause_nop_r1: assert property (@(posedge clk) disable iff (rst)
    !pre_q && (st_q != ST_PRE) |-> (cmd == CMD_NOP));

  p_mrs_once_after_pre_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MRS) |-> (pre_q && !mrs_q));

  p_ref_total_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (ref_q == REF_W'(REF_COUNT)) && mrs_q);

  p_order_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REF) |-> (mrs_q == !REFRESH_FIRST));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int              ADDR_W        = 12,
  parameter int              CLK_MHZ       = 100,
  parameter int              PAUSE_US      = 200,
  parameter int              T_RP          = 2,
  parameter int              T_RC          = 7,
  parameter int              T_RSC         = 2,
  parameter int              REF_COUNT     = 8,
  parameter bit              REFRESH_FIRST = 1'b0,
  parameter logic [ADDR_W-1:0] MODE_WORD   = 12'h032
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              clk_en,
  output logic              dq_mask,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int MAX_A     = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int MAX_B     = (MAX_A > T_RSC) ? MAX_A : T_RSC;
  localparam int MAX_WAIT  = (PAUSE_CYC > MAX_B) ? PAUSE_CYC : MAX_B;
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);
  localparam int AP_BIT    = 10;

  logic             load, expired;
  logic [CNT_W-1:0] load_val;
  init_cmd_e        cmd;

  sdram_init_timer #(
    .W       (CNT_W),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sdram_init_ctrl #(
    .CNT_W         (CNT_W),
    .T_RP          (T_RP),
    .T_RC          (T_RC),
    .T_RSC         (T_RSC),
    .REF_COUNT     (REF_COUNT),
    .REFRESH_FIRST (REFRESH_FIRST)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .expired  (expired),
    .load     (load),
    .load_val (load_val),
    .cmd      (cmd),
    .done     (init_done)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_pins(cmd);
  assign clk_en  = 1'b1;
  assign dq_mask = !init_done;

  always_comb begin
    addr = '0;
    case (cmd)
      CMD_PRE: addr[AP_BIT] = 1'b1;
      CMD_MRS: addr = MODE_WORD;
      default: addr = '0;
    endcase
  end

  // Spacing checker: idle cycles since the last command on the bus.
  localparam int GAP_W = CNT_W + 1;
  logic [GAP_W-1:0] gap_q, gap_need;
  init_cmd_e        last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      last_q <= CMD_NOP;
    end else if (cmd != CMD_NOP) begin
      gap_q  <= '0;
      last_q <= cmd;
    end else if (gap_q != {GAP_W{1'b1}}) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  always_comb begin
    case (last_q)
      CMD_PRE: gap_need = GAP_W'(T_RP);
      CMD_MRS: gap_need = GAP_W'(T_RSC);
      CMD_REF: gap_need = GAP_W'(T_RC);
      default: gap_need = GAP_W'(PAUSE_CYC);
    endcase
  end

  // Covers R6 and R8 too: each command waits out its predecessor's gap.
  p_cmd_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |-> (gap_q >= gap_need));

  p_mask_until_done_r2: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (dq_mask && clk_en));

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> (last_q == CMD_NOP) && (gap_q == GAP_W'(PAUSE_CYC)));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0111);

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int CLK_MHZ    = 10;
  localparam int PAUSE_US   = 2;
  localparam int P          = CLK_MHZ * PAUSE_US;
  localparam int T_RP       = 2;
  localparam int T_RSC      = 3;
  localparam int T_RC       = 4;
  localparam int N_REF      = 8;
  localparam logic [ADDR_W-1:0] MODE = 12'h237;
  localparam int TOTAL = P + 1 + T_RP + (1 + T_RSC) + N_REF * (1 + T_RC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   errors = 0;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done;
  logic [ADDR_W-1:0] a_addr, b_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP),
    .T_RC(T_RC), .T_RSC(T_RSC), .REF_COUNT(N_REF), .REFRESH_FIRST(1'b0),
    .MODE_WORD(MODE)
  ) i_sdram_init_seq (
    .clk(clk), .rst(rst), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas),
    .we_n(a_we), .clk_en(a_cke), .dq_mask(a_dqm), .addr(a_addr),
    .init_done(a_done)
  );

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP),
    .T_RC(T_RC), .T_RSC(T_RSC), .REF_COUNT(N_REF), .REFRESH_FIRST(1'b1),
    .MODE_WORD(MODE)
  ) i_sdram_init_seq_rf (
    .clk(clk), .rst(rst), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas),
    .we_n(b_we), .clk_en(b_cke), .dq_mask(b_dqm), .addr(b_addr),
    .init_done(b_done)
  );

  // Kind of cycle k: 0 pause, 1 PRE, 2 after PRE, 3 MRS, 4 after MRS,
  // 5 REF, 6 after REF, 7 done.
  function automatic int kind_at(int k, bit first);
    int t;
    if (k < P) return 0;
    if (k == P) return 1;
    t = k - P - 1;
    if (t < T_RP) return 2;
    t = t - T_RP;
    for (int s = 0; s <= N_REF; s++) begin
      bit is_mrs = first ? (s == N_REF) : (s == 0);
      int len    = is_mrs ? 1 + T_RSC : 1 + T_RC;
      if (t < len) begin
        if (t == 0) return is_mrs ? 3 : 5;
        return is_mrs ? 4 : 6;
      end
      t = t - len;
    end
    return 7;
  endfunction

  // {done, dqm, cke, cs_n, ras_n, cas_n, we_n, addr}
  function automatic logic [ADDR_W+6:0] expect_of(int kind);
    logic [3:0]        pins = 4'b0111;
    logic [ADDR_W-1:0] ad   = '0;
    if (kind == 1) begin pins = 4'b0010; ad[10] = 1'b1; end
    if (kind == 3) begin pins = 4'b0000; ad = MODE; end
    if (kind == 5) pins = 4'b0001;
    return {(kind == 7), (kind != 7), 1'b1, pins, ad};
  endfunction

  function automatic string tag_of(int kind);
    case (kind)
      0: return "R1 R2";
      1: return "R3";
      2: return "R4";
      3: return "R5 R9";
      4: return "R6";
      5: return "R7 R9";
      6: return "R8";
      default: return "R10 R2";
    endcase
  endfunction

  task automatic check_vec(string who, string tag, logic [ADDR_W+6:0] act,
                           logic [ADDR_W+6:0] exp, int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, who, k, act, exp);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int a_refs, b_refs, a_mrs_k, b_mrs_k, a_ref0_k, b_ref0_k;

  // Sweeps cycles 0..last after release; k=0 is the cycle right after release.
  task automatic sweep(int last, string extra);
    a_refs = 0; b_refs = 0; a_mrs_k = -1; b_mrs_k = -1; a_ref0_k = -1; b_ref0_k = -1;
    for (int k = 0; k <= last; k++) begin
      int ka = kind_at(k, 1'b0);
      int kb = kind_at(k, 1'b1);
      check_vec("order0", {tag_of(ka), extra},
                {a_done, a_dqm, a_cke, a_cs, a_ras, a_cas, a_we, a_addr}, expect_of(ka), k);
      check_vec("order1", {tag_of(kb), extra},
                {b_done, b_dqm, b_cke, b_cs, b_ras, b_cas, b_we, b_addr}, expect_of(kb), k);
      if ({a_cs, a_ras, a_cas, a_we} == 4'b0001) begin
        if (a_ref0_k < 0) a_ref0_k = k;
        a_refs++;
      end
      if ({b_cs, b_ras, b_cas, b_we} == 4'b0001) begin
        if (b_ref0_k < 0) b_ref0_k = k;
        b_refs++;
      end
      if ({a_cs, a_ras, a_cas, a_we} == 4'b0000) a_mrs_k = k;
      if ({b_cs, b_ras, b_cas, b_we} == 4'b0000) b_mrs_k = k;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state (R1): NOP, masks high, not done.
    check_vec("order0", "R1 reset", {a_done, a_dqm, a_cke, a_cs, a_ras, a_cas, a_we, a_addr},
              expect_of(0), -1);
    check_vec("order1", "R1 reset", {b_done, b_dqm, b_cke, b_cs, b_ras, b_cas, b_we, b_addr},
              expect_of(0), -1);
    rst = 1'b0;
    sweep(TOTAL + 12, "");
    check_int("R7 refresh count order0", a_refs, N_REF);
    check_int("R7 refresh count order1", b_refs, N_REF);
    check_int("R9 mrs before refresh order0", int'(a_mrs_k < a_ref0_k), 1);
    check_int("R9 refresh before mrs order1", int'(b_ref0_k < b_mrs_k), 1);

    // R11: reset in the middle of the refresh burst, then replay.
    rst = 1'b1;
    @(negedge clk);
    check_vec("order0", "R1 R11 reset", {a_done, a_dqm, a_cke, a_cs, a_ras, a_cas, a_we, a_addr},
              expect_of(0), -1);
    rst = 1'b0;
    sweep(P + T_RP + 12, " R11");
    rst = 1'b1;
    @(negedge clk);
    check_vec("order1", "R11 reset", {b_done, b_dqm, b_cke, b_cs, b_ras, b_cas, b_we, b_addr},
              expect_of(0), -1);
    rst = 1'b0;
    sweep(TOTAL + 6, " R11");
    check_int("R11 R7 replay refresh count order0", a_refs, N_REF);
    check_int("R11 R7 replay refresh count order1", b_refs, N_REF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule